// File: doc/BRIEF.md
# Composite Single-Port Memory Array

This block presents one logical single-port memory, 128 bits wide and 2048 words deep, with a write enable for each byte. Inside, it is assembled from smaller leaf arrays of 1024 words. Leaves placed side by side make up the width. Two depth banks make up the full depth, and the upper address bit picks between them. Only the addressed bank is enabled. The read data of the banks pass through a multiplexer whose select is registered together with the read. The output therefore tracks the bank that was read, even when the next request goes to the other bank.

There are two ways to get byte masking. With mask-capable leaves the block uses 64-bit leaves and drives their byte mask pins. With leaves that have no mask input it uses sixteen 8-bit leaves per bank, and each one gets its own write enable taken from its byte-enable bit. Each leaf control pin (chip enable, write enable, read enable, mask) has its own polarity parameter. The wrapper inverts a pin when that pin is active low, so behaviour at the ports does not change. A behavioural leaf model is part of the block.

Top module: `sram_composite`

## Requirements
- R1: After reset is released, `rdata_o` is all zero until the first read completes.
- R2: A read presented with `req_i=1`, `we_i=0` in one cycle drives the word onto `rdata_o` in the next cycle, one clock of latency.
- R3: A write with all byte enables set stores `wdata_i`, and a later read of the same address returns it. `addr_i[10]` selects the depth bank and `addr_i[9:0]` the word, so the same low address in the two banks holds independent words.
- R4: `be_i[i]=1` writes bits `8*i+7:8*i` of `wdata_i`. A byte whose enable is 0 keeps its previous contents.
- R5: A write with `be_i` all zero leaves the addressed word unchanged.
- R6: In a cycle with no read request (idle or write), `rdata_o` holds its value in the next cycle.
- R7: Only the bank that `addr_i[10]` selects receives chip enable on a request. No bank is enabled without a request.
- R8: With `LEAF_HAS_MASK=0` the array is built from 8-bit leaves, each with its own write enable, and behaves the same at the ports as the mask-capable build.
- R9: Each polarity parameter (`CE_ACT_HI`, `WE_ACT_HI`, `RE_ACT_HI`, `MASK_ACT_HI`, where 1 means active high and 0 means active low) changes only the leaf pin level, never the port behaviour.
- R10: The bank select of a read is registered, so back-to-back reads of alternating banks each return their own bank's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Word address, bit 10 selects the bank |
| wdata_i | input | 128 | Write data |
| be_i | input | 16 | Byte write enables, bit i covers byte i |
| rdata_o | output | 128 | Read data, one cycle after the read |

## Verification
A wrong bank decode or a stale select register shows at `rdata_o` in the cycle right after the read: the word comes from the other bank, or a word that should have stayed intact gets overwritten and shows up on the next read of it. A polarity slip on a leaf pin shows up as lost writes, spurious writes or an output that never updates, so a comparison against a flat reference catches it within one read-after-write pair. Two builds receive the same stimulus at the same time: mask-capable leaves with active-high pins, and 8-bit leaves with active-low pins.

// File: rtl/sram_arr_pkg.sv
`timescale 1ns/1ps
package sram_arr_pkg;
  // drive a logical level onto a leaf pin of given polarity
  function automatic logic pin_lvl(input bit act_hi, input logic v);
    return act_hi ? v : ~v;
  endfunction
  // read back a leaf pin as a logical level
  function automatic logic pin_act(input bit act_hi, input logic p);
    return act_hi ? p : ~p;
  endfunction
endpackage

// File: rtl/sram_leaf.sv
`timescale 1ns/1ps
module sram_leaf
  import sram_arr_pkg::*;
#(
  parameter int W         = 64,
  parameter int DEPTH     = 1024,
  parameter int AW        = $clog2(DEPTH),
  parameter bit HAS_MASK  = 1'b1,
  parameter int GRAN      = 8,
  parameter int MASK_W    = HAS_MASK ? W / GRAN : 1,
  parameter bit CE_ACT_HI = 1'b1,
  parameter bit WE_ACT_HI = 1'b1,
  parameter bit RE_ACT_HI = 1'b1,
  parameter bit MASK_ACT_HI = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [W-1:0]      din_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [W-1:0]      dout_o
);
  logic [W-1:0] mem [DEPTH];
  logic ce_a, we_a, re_a;

  assign ce_a = pin_act(CE_ACT_HI, ce_i);
  assign we_a = pin_act(WE_ACT_HI, we_i);
  assign re_a = pin_act(RE_ACT_HI, re_i);

  if (HAS_MASK) begin : g_mask
    logic [MASK_W-1:0] mask_a;
    assign mask_a = MASK_ACT_HI ? mask_i : ~mask_i;
    always_ff @(posedge clk_i) begin
      if (ce_a && we_a) begin
        for (int k = 0; k < MASK_W; k++) begin
          if (mask_a[k]) mem[addr_i][k*GRAN +: GRAN] <= din_i[k*GRAN +: GRAN];
        end
      end
    end
  end else begin : g_nomask
    logic unused_mask;
    assign unused_mask = ^mask_i;
    always_ff @(posedge clk_i) begin
      if (ce_a && we_a) mem[addr_i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    dout_o <= '0;
    else if (ce_a && re_a && !we_a) dout_o <= mem[addr_i];
  end
endmodule

// File: rtl/sram_bank.sv
`timescale 1ns/1ps
module sram_bank
  import sram_arr_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int LEAF_W    = 64,
  parameter int LEAF_AW   = 10,
  parameter int GRAN      = 8,
  parameter bit HAS_MASK  = 1'b1,
  parameter bit CE_ACT_HI = 1'b1,
  parameter bit WE_ACT_HI = 1'b1,
  parameter bit RE_ACT_HI = 1'b1,
  parameter bit MASK_ACT_HI = 1'b1,
  localparam int NLEAF    = DATA_W / LEAF_W,
  localparam int BE_W     = DATA_W / GRAN,
  localparam int BPL      = LEAF_W / GRAN,
  localparam int LMASK_W  = HAS_MASK ? BPL : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               we_i,
  input  logic [LEAF_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]    be_i,
  output logic [DATA_W-1:0]  rdata_o
);
  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    logic               ce_p, we_p, re_p;
    logic [LMASK_W-1:0] mask_p;
    logic               we_l;

    if (HAS_MASK) begin : g_m
      assign we_l   = we_i;
      assign mask_p = MASK_ACT_HI ? be_i[g*BPL +: BPL] : ~be_i[g*BPL +: BPL];
    end else begin : g_e
      // narrow leaf: its byte enable becomes its write enable
      assign we_l   = we_i & (&be_i[g*BPL +: BPL]);
      assign mask_p = {LMASK_W{pin_lvl(MASK_ACT_HI, 1'b1)}};
    end

    assign ce_p = pin_lvl(CE_ACT_HI, ce_i);
    assign we_p = pin_lvl(WE_ACT_HI, we_l);
    assign re_p = pin_lvl(RE_ACT_HI, ~we_i);

    sram_leaf #(
      .W(LEAF_W), .DEPTH(2**LEAF_AW), .AW(LEAF_AW), .HAS_MASK(HAS_MASK),
      .GRAN(GRAN), .MASK_W(LMASK_W), .CE_ACT_HI(CE_ACT_HI),
      .WE_ACT_HI(WE_ACT_HI), .RE_ACT_HI(RE_ACT_HI), .MASK_ACT_HI(MASK_ACT_HI)
    ) u_leaf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ce_p),
      .we_i   (we_p),
      .re_i   (re_p),
      .addr_i (addr_i),
      .din_i  (wdata_i[g*LEAF_W +: LEAF_W]),
      .mask_i (mask_p),
      .dout_o (rdata_o[g*LEAF_W +: LEAF_W])
    );
  end
endmodule

// File: rtl/sram_rd_mux.sv
`timescale 1ns/1ps
module sram_rd_mux #(
  parameter int DATA_W  = 128,
  parameter int NBANK   = 2,
  parameter int BANK_AW = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [BANK_AW-1:0] bank_i,
  input  logic [DATA_W-1:0]  bank_rdata_i [NBANK],
  output logic [BANK_AW-1:0] sel_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [BANK_AW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (rd_en_i) sel_q <= bank_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel_q == BANK_AW'(b)) rdata_o = bank_rdata_i[b];
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/sram_composite.sv
`timescale 1ns/1ps
module sram_composite #(
  parameter int DATA_W        = 128,
  parameter int DEPTH         = 2048,
  parameter int LEAF_DEPTH    = 1024,
  parameter int GRAN          = 8,
  parameter bit LEAF_HAS_MASK = 1'b1,
  parameter int MASK_LEAF_W   = 64,
  parameter bit CE_ACT_HI     = 1'b1,
  parameter bit WE_ACT_HI     = 1'b1,
  parameter bit RE_ACT_HI     = 1'b1,
  parameter bit MASK_ACT_HI   = 1'b1,
  localparam int AW      = $clog2(DEPTH),
  localparam int LEAF_AW = $clog2(LEAF_DEPTH),
  localparam int NBANK   = DEPTH / LEAF_DEPTH,
  localparam int BANK_AW = AW - LEAF_AW,
  localparam int BE_W    = DATA_W / GRAN,
  localparam int LEAF_W  = LEAF_HAS_MASK ? MASK_LEAF_W : GRAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BANK_AW-1:0] bank_idx;
  logic [NBANK-1:0]   bank_ce;
  logic [DATA_W-1:0]  bank_rdata [NBANK];
  logic [BANK_AW-1:0] rd_bank_q;

  assign bank_idx = addr_i[AW-1:LEAF_AW];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_ce[b] = req_i && (bank_idx == BANK_AW'(b));

    sram_bank #(
      .DATA_W(DATA_W), .LEAF_W(LEAF_W), .LEAF_AW(LEAF_AW), .GRAN(GRAN),
      .HAS_MASK(LEAF_HAS_MASK), .CE_ACT_HI(CE_ACT_HI), .WE_ACT_HI(WE_ACT_HI),
      .RE_ACT_HI(RE_ACT_HI), .MASK_ACT_HI(MASK_ACT_HI)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ce_i    (bank_ce[b]),
      .we_i    (we_i),
      .addr_i  (addr_i[LEAF_AW-1:0]),
      .wdata_i (wdata_i),
      .be_i    (be_i),
      .rdata_o (bank_rdata[b])
    );
  end

  sram_rd_mux #(.DATA_W(DATA_W), .NBANK(NBANK), .BANK_AW(BANK_AW)) u_rd_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (req_i && !we_i),
    .bank_i       (bank_idx),
    .bank_rdata_i (bank_rdata),
    .sel_o        (rd_bank_q),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/sram_composite_chk.sv
`timescale 1ns/1ps
module sram_composite_chk #(
  parameter int DATA_W  = 128,
  parameter int AW      = 11,
  parameter int LEAF_AW = 10,
  parameter int BE_W    = 16,
  parameter int NBANK   = 2,
  parameter int BANK_AW = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [BE_W-1:0]    be_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NBANK-1:0]   bank_ce,
  input logic [BANK_AW-1:0] rd_bank_q
);
  // R6
  hold_when_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R7
  ce_only_addressed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ($onehot(bank_ce) && bank_ce[addr_i[AW-1:LEAF_AW]]));

  // R7
  ce_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (bank_ce == '0));

  // R10
  bank_sel_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> (rd_bank_q == $past(addr_i[AW-1:LEAF_AW])));

  // R3
  wr_then_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && $past(req_i && we_i && (&be_i)) && (addr_i == $past(addr_i)))
    |=> (rdata_o == $past(wdata_i, 2)));
endmodule

bind sram_composite sram_composite_chk #(
  .DATA_W(DATA_W), .AW(AW), .LEAF_AW(LEAF_AW), .BE_W(BE_W),
  .NBANK(NBANK), .BANK_AW(BANK_AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .be_i      (be_i),
  .rdata_o   (rdata_o),
  .bank_ce   (bank_ce),
  .rd_bank_q (rd_bank_q)
);

// File: tb/sram_composite_tb.sv
`timescale 1ns/1ps
module sram_composite_tb;
  localparam int DW = 128;
  localparam int AW = 11;
  localparam int BW = 16;

  typedef struct {
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [BW-1:0] be = '0;
  logic [DW-1:0] rdata_a, rdata_b;

  logic [DW-1:0] ref_mem [2**AW];
  exp_t          exp_q [$];
  logic [DW-1:0] last_exp = '0;
  string         last_tag = "R1";
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;
  logic [9:0]    pool [16];

  always #2 clk = ~clk;

  // mask-capable 64-bit leaves, active-high pins
  sram_composite u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata_a)
  );

  // R8 R9: 8-bit leaves, every pin active low
  sram_composite #(
    .LEAF_HAS_MASK(1'b0), .CE_ACT_HI(1'b0), .WE_ACT_HI(1'b0),
    .RE_ACT_HI(1'b0), .MASK_ACT_HI(1'b0)
  ) u_dut_lo (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata_b)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: sample 1 ns after each rising edge
  always @(posedge clk) begin
    logic rd;
    rd = rst_n && req && !we;
    #1;
    if (rst_n && !done) begin
      if (rd) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 act=unexpected read exp=empty queue");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_exp = e.d;
          last_tag = e.tag;
        end
      end
      check({last_tag, rd ? "" : " R6 hold"}, rdata_a, last_exp);
      check({last_tag, " R8 R9 narrow/low"}, rdata_b, last_exp);
    end
  end

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] m);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = m;
    for (int i = 0; i < BW; i++) if (m[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = $urandom; wdata = {4{$urandom}};
    e.d = ref_mem[a];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; we = $urandom; addr = $urandom; wdata = {4{$urandom}}; be = $urandom;
    end
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) pool[i] = 10'($urandom);
    pool[0] = 10'h000; pool[1] = 10'h3ff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_idle(3); // R1: monitor checks zero output
    // fill pool in both banks, full mask
    for (int i = 0; i < 16; i++) begin
      do_wr({1'b0, pool[i]}, rnd128(), '1);
      do_wr({1'b1, pool[i]}, rnd128(), '1);
    end
    // R3 R7: same low address, independent banks
    do_rd({1'b0, pool[0]}, "R3 R7 bank0");
    do_rd({1'b1, pool[0]}, "R3 R7 bank1");
    do_rd({1'b1, pool[1]}, "R3 top word");
    // R2: write then immediate read
    do_wr({1'b0, pool[2]}, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, '1);
    do_rd({1'b0, pool[2]}, "R2 latency");
    // R4: partial masks
    do_wr({1'b1, pool[3]}, rnd128(), 16'h00ff);
    do_rd({1'b1, pool[3]}, "R4 low half");
    do_wr({1'b0, pool[4]}, rnd128(), 16'ha5c3);
    do_rd({1'b0, pool[4]}, "R4 scattered");
    do_wr({1'b0, pool[4]}, rnd128(), 16'h8001);
    do_rd({1'b0, pool[4]}, "R4 edge bytes");
    // R5: empty mask
    do_wr({1'b1, pool[5]}, ~ref_mem[{1'b1, pool[5]}], 16'h0000);
    do_rd({1'b1, pool[5]}, "R5 no-op write");
    // R10: alternating banks back to back
    for (int i = 0; i < 6; i++) do_rd({i[0], pool[6]}, "R10 alternate");
    // R6: write to other bank and idle after a read
    do_rd({1'b0, pool[7]}, "R6 before hold");
    do_wr({1'b1, pool[7]}, rnd128(), '1);
    do_idle(2);
    do_rd({1'b1, pool[7]}, "R6 after hold");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      int k;
      a = {1'($urandom), pool[$urandom % 16]};
      k = $urandom % 4;
      if (k == 0)      do_wr(a, rnd128(), BW'($urandom));
      else if (k == 1) do_wr(a, rnd128(), '1);
      else if (k == 2) do_rd(a, "R3 R4 random");
      else             do_idle(1);
    end
    do_idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 act=%0d pending exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule